// File: doc/BRIEF.md
# Multi-Level Interrupt Mask Controller

This block gathers device interrupt request lines for a processor that services several priority levels. Four levels are provided, numbered 3 through 6. Each level takes four level-sensitive request lines, one per device. Each level exposes two byte-wide registers on a simple memory-mapped bus. The status register shows the live request lines. The enable register holds a per-device mask.

For each level the block raises one request output whenever at least one device on that level is both requesting and enabled. Software changes the enable mask with a set/clear write. The top bit of the written byte selects the operation: when it is 1, the ones in the low nibble are added to the mask; when it is 0, those same ones are removed from it. Device bits written as zero keep their current enable state. Because of this, a driver for one device never has to read, modify and write back the mask shared with its neighbours.

A small bus-access state machine handles the bus side. Its states are `ST_IDLE` (no access), `ST_READ` (read data is being presented) and `ST_WRITE` (a write was taken). On each clock edge the next state is chosen as follows:
- any state goes to `ST_WRITE` when the write strobe is high;
- otherwise it goes to `ST_READ` when the read strobe is high;
- otherwise it goes to `ST_IDLE`.

Read data is captured at the edge that samples the read strobe. It is presented on the read-data port only while the machine is in `ST_READ`.

Top module: `irq_level_ctl`

## Requirements
- R1: For level L (3..6), the status register is at byte offset 0x100 + 0x10·L (0x130, 0x140, 0x150, 0x160). The enable register sits 4 bytes higher (0x134, 0x144, 0x154, 0x164). Device requests for level L arrive on `dev_req[4·(L-3)+3 : 4·(L-3)]`, and device d of the level uses bit d.
- R2: A status read returns the level's live request lines in bits 3..0, whatever the enable state, with bits 7..4 zero.
- R3: An enable read returns the level's enable mask in bits 3..0, with bits 7..4 zero.
- R4: An enable write with bit 7 = 1 turns on each device whose bit in 3..0 is 1 and leaves the other devices unchanged (0x81 enables device 0, 0x86 enables devices 1 and 2).
- R5: An enable write with bit 7 = 0 turns off each device whose bit in 3..0 is 1 and leaves the other devices unchanged (0x02 disables device 1).
- R6: `irq_lvl[L-3]` is high exactly when the AND of that level's request lines and its enable mask is non-zero.
- R7: After reset every enable bit is 0, every `irq_lvl` bit is 0, and `bus_rdata` is 0.
- R8: An enable write changes the level's `irq_lvl` bit at the same clock edge that takes the write, with no further delay.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets, and writes to status registers, change no enable bit.
- R10: Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` was sampled high. In any cycle that does not follow a read, `bus_rdata` is 0.
- R11: When `bus_wr` and `bus_rd` are high in the same cycle, the write is performed and the read is dropped, so `bus_rdata` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle after the read strobe |
| dev_req | input | 16 | Level-sensitive device requests, four per level, level 3 in the low nibble |
| irq_lvl | output | 4 | Per-level request to the processor, bit 0 for level 3 |

## Verification
The embedded assertions check on every cycle the following rules:
- the set and clear arithmetic of each enable mask across a write;
- that the mask holds steady when no write is aimed at it;
- that a level never requests without a device line high;
- that at most one level's enable write is decoded per cycle;
- that unmapped reads and write-over-read collisions leave the read-data port at zero.

Only the bench's sweeps can show that the address map selects the intended register. They also show that status reads track the raw inputs under every enable pattern. Finally, they show that the full 16×16 request/enable product of every level reaches the right output.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    // Bus-access state of the register port.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_t;

    // Register offsets inside one level's 16-byte window.
    localparam logic [3:0] OFF_STATUS = 4'h0;
    localparam logic [3:0] OFF_ENABLE = 4'h4;

    // Upper address nibble that selects the interrupt register page.
    localparam logic [3:0] PAGE_IRQ = 4'h1;

endpackage

// File: rtl/irq_level_slice.sv
module irq_level_slice #(
    parameter int DEV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,      // decoded enable-register write for this level
    input  logic             set_mode,   // write data bit 7: 1 = set, 0 = clear
    input  logic [DEV_W-1:0] wr_mask,    // write data bits DEV_W-1..0
    input  logic [DEV_W-1:0] req,        // raw device requests of this level
    output logic [DEV_W-1:0] en_q,
    output logic             irq
);

    logic [DEV_W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (en_wr) begin
            if (set_mode) en_d = en_q | wr_mask;
            else          en_d = en_q & ~wr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // Combinational request so a write is seen on the edge that takes it (R8).
    assign irq = |(req & en_q);

    // R4: set write ORs the mask in
    a_r4_set_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && set_mode) |=> (en_q == ($past(en_q) | $past(wr_mask))));

    // R5: clear write removes the mask
    a_r5_clear_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !set_mode) |=> (en_q == ($past(en_q) & ~$past(wr_mask))));

    // R9: without a write the mask holds
    a_r9_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q));

    // R6: no request without a device line
    a_r6_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (req != '0));

endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int NUM_LVL   = 4,
    parameter int FIRST_LVL = 3,
    parameter int DEV_W     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [NUM_LVL*DEV_W-1:0] status_flat,
    input  logic [NUM_LVL*DEV_W-1:0] enable_flat,
    output logic [NUM_LVL-1:0]       en_wr,
    output logic [DATA_W-1:0]        bus_rdata
);

    localparam int PAGE_W = ADDR_W - 8;

    acc_state_t        state_q, state_d;
    logic [DATA_W-1:0] rd_val, hold_q;
    logic              mapped;
    logic              page_hit;
    logic [3:0]        lvl_field;
    logic [3:0]        reg_off;

    assign page_hit  = (bus_addr[ADDR_W-1:8] == PAGE_W'(PAGE_IRQ));
    assign lvl_field = bus_addr[7:4];
    assign reg_off   = bus_addr[3:0];

    // Register decode and read mux
    always_comb begin
        rd_val = '0;
        mapped = 1'b0;
        en_wr  = '0;
        for (int k = 0; k < NUM_LVL; k++) begin
            if (page_hit && lvl_field == 4'(FIRST_LVL + k)) begin
                if (reg_off == OFF_STATUS) begin
                    rd_val[DEV_W-1:0] = status_flat[k*DEV_W +: DEV_W];
                    mapped = 1'b1;
                end else if (reg_off == OFF_ENABLE) begin
                    rd_val[DEV_W-1:0] = enable_flat[k*DEV_W +: DEV_W];
                    mapped = 1'b1;
                    en_wr[k] = bus_wr;
                end
            end
        end
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (bus_wr)      state_d = ST_WRITE;
                else if (bus_rd) state_d = ST_READ;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (bus_rd && !bus_wr) hold_q <= rd_val;
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            ST_READ:  bus_rdata = hold_q;
            ST_IDLE:  bus_rdata = '0;
            ST_WRITE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

    // R10: a lone read strobe moves to the read state
    a_r10_read_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> (state_q == ST_READ));

    // R11: collision drops the read
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd) |=> (bus_rdata == '0));

    // R9: unmapped reads give zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !mapped) |=> (bus_rdata == '0));

    // R1: at most one level's enable is written per cycle
    a_r1_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_wr));

endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int NUM_LVL   = 4,
    parameter int FIRST_LVL = 3,
    parameter int DEV_W     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_LVL*DEV_W-1:0] dev_req,
    output logic [NUM_LVL-1:0]       irq_lvl
);

    localparam int REQ_W = NUM_LVL * DEV_W;

    logic [REQ_W-1:0]   enable_flat;
    logic [NUM_LVL-1:0] en_wr;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-2:DEV_W];

    irq_bus_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LVL(NUM_LVL),
        .FIRST_LVL(FIRST_LVL), .DEV_W(DEV_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .status_flat(dev_req),
        .enable_flat(enable_flat),
        .en_wr      (en_wr),
        .bus_rdata  (bus_rdata)
    );

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
        irq_level_slice #(.DEV_W(DEV_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_wr   (en_wr[k]),
            .set_mode(bus_wdata[DATA_W-1]),
            .wr_mask (bus_wdata[DEV_W-1:0]),
            .req     (dev_req[k*DEV_W +: DEV_W]),
            .en_q    (enable_flat[k*DEV_W +: DEV_W]),
            .irq     (irq_lvl[k])
        );
    end

    // R7: right after reset release nothing is requesting
    a_r7_quiet_after_reset: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (irq_lvl == '0 && bus_rdata == '0));

endmodule

// File: tb/test_irq_level_ctl.sv
`timescale 1ns/1ps
module test_irq_level_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] dev_req = '0;
    logic [3:0]  irq_lvl;

    int n_vec = 0;
    int n_bad = 0;
    logic [3:0] en_m [4];

    always #5 clk = ~clk;

    irq_level_ctl i_irq_level_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_req(dev_req), .irq_lvl(irq_lvl)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [11:0] st_addr(input int lvl);
        return 12'(12'h100 + 16 * (lvl + 3));
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = |(dev_req[k*4 +: 4] & en_m[k]);
        return r;
    endfunction

    function automatic bit is_mapped(input logic [11:0] a);
        return a[11:8] == 4'h1 && a[7:4] >= 4'd3 && a[7:4] <= 4'd6 &&
               (a[3:0] == 4'h0 || a[3:0] == 4'h4);
    endfunction

    task automatic model_write(input int lvl, input logic [7:0] d);
        if (d[7]) en_m[lvl] = en_m[lvl] | d[3:0];
        else      en_m[lvl] = en_m[lvl] & ~d[3:0];
    endtask

    task automatic check_enables(input string tag);
        logic [7:0] v;
        for (int k = 0; k < 4; k++) begin
            do_read(st_addr(k) + 12'h4, v);
            chk(v == {4'h0, en_m[k]}, tag, v, en_m[k]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        for (int k = 0; k < 4; k++) en_m[k] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        chk(irq_lvl == 4'h0, "R7 irq after reset", irq_lvl, 0);
        chk(bus_rdata == 8'h0, "R7 rdata after reset", bus_rdata, 0);
        check_enables("R7 R3 enable after reset");

        // R4 R5: documented examples on level 4
        do_write(12'h144, 8'h81); model_write(1, 8'h81);
        do_write(12'h144, 8'h86); model_write(1, 8'h86);
        do_read(12'h144, v);
        chk(v == 8'h07, "R4 example set", v, 8'h07);
        do_write(12'h144, 8'h02); model_write(1, 8'h02);
        do_read(12'h144, v);
        chk(v == 8'h05, "R5 example clear", v, 8'h05);

        // R4 R5 R8 R3: set/clear sweep on every level
        dev_req = 16'hFFFF;
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 16; m++) begin
                do_write(st_addr(k) + 12'h4, 8'h80 | 8'(m)); model_write(k, 8'h80 | 8'(m));
                chk(irq_lvl == exp_irq(), "R8 irq after set", irq_lvl, exp_irq());
                do_read(st_addr(k) + 12'h4, v);
                chk(v == {4'h0, en_m[k]}, "R4 set sweep", v, en_m[k]);
                do_write(st_addr(k) + 12'h4, 8'(m ^ 10)); model_write(k, 8'(m ^ 10));
                chk(irq_lvl == exp_irq(), "R8 irq after clear", irq_lvl, exp_irq());
                do_read(st_addr(k) + 12'h4, v);
                chk(v == {4'h0, en_m[k]}, "R5 clear sweep", v, en_m[k]);
            end
        end

        // R6 R2 R1: request x enable product per level
        for (int k = 0; k < 4; k++) begin
            for (int e = 0; e < 16; e++) begin
                do_write(st_addr(k) + 12'h4, 8'h0F); model_write(k, 8'h0F);
                do_write(st_addr(k) + 12'h4, 8'h80 | 8'(e)); model_write(k, 8'h80 | 8'(e));
                for (int r = 0; r < 16; r++) begin
                    @(negedge clk);
                    dev_req = {4{4'(r) ^ 4'hF}};
                    dev_req[k*4 +: 4] = 4'(r);
                    @(negedge clk);
                    chk(irq_lvl == exp_irq(), "R6 irq product", irq_lvl, exp_irq());
                    do_read(st_addr(k), v);
                    chk(v == {4'h0, 4'(r)}, "R2 R1 status read", v, r);
                end
            end
        end

        // R10: rdata returns to zero after the read cycle
        do_read(12'h134, v);
        @(negedge clk);
        chk(bus_rdata == 8'h0, "R10 rdata idle", bus_rdata, 0);

        // R11: simultaneous write and read
        @(negedge clk);
        bus_addr = 12'h154; bus_wdata = 8'h8F; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        model_write(2, 8'h8F);
        chk(bus_rdata == 8'h0, "R11 read dropped", bus_rdata, 0);
        check_enables("R11 write taken");

        // R9: status writes and unmapped accesses
        do_write(12'h134, 8'h0F); model_write(0, 8'h0F); do_write(12'h134, 8'h85); model_write(0, 8'h85);
        do_write(12'h144, 8'h0F); model_write(1, 8'h0F); do_write(12'h144, 8'h8A); model_write(1, 8'h8A);
        do_write(12'h154, 8'h0F); model_write(2, 8'h0F); do_write(12'h154, 8'h83); model_write(2, 8'h83);
        do_write(12'h164, 8'h0F); model_write(3, 8'h0F); do_write(12'h164, 8'h8C); model_write(3, 8'h8C);
        dev_req = 16'hFFFF;
        for (int k = 0; k < 4; k++) begin
            do_write(st_addr(k), 8'h8F);
            do_write(st_addr(k), 8'h0F);
        end
        check_enables("R9 status write ignored");
        for (int a = 0; a < 4096; a++) begin
            if (!is_mapped(12'(a))) begin
                do_read(12'(a), v);
                chk(v == 8'h0, "R9 unmapped read", v, 0);
                do_write(12'(a), 8'h8F);
                do_write(12'(a), 8'h0F);
            end
        end
        check_enables("R9 unmapped write ignored");
        @(negedge clk);
        chk(irq_lvl == exp_irq(), "R9 irq unchanged", irq_lvl, exp_irq());

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule